// File: doc/BRIEF.md
# Cache-as-RAM address mapper

This block serves CPU loads and stores that fall in a 64 MB address window starting at 0x7C000000, at the point where the operand cache is set up to act as on-chip RAM. Two 4 KB halves of the cache data store hold the RAM. The block picks the half, forms the byte address inside the data store, and performs byte, word, long and 32-byte burst transfers. The data store itself is built inside the block as eight byte-enabled word lanes, so that one burst touches one row across all lanes.

Three configuration inputs control the mapping. An index-mode select chooses which address bit picks the half. The other two are a RAM-mode enable and a cache enable, and both must be set for the window to be live. Accesses that cannot be served are flagged as unmapped: they return zero and change nothing. Every request is answered exactly one cycle later.

Top module: `carram_mapper`

## Requirements
- R1: A request whose address bits 31:26 are not 6'b011111 (outside 0x7C000000..0x7FFFFFFF) is answered with resp_unmapped high.
- R2: A request made while cfg_ram_en or cfg_cache_en is low is answered with resp_unmapped high, whatever its address.
- R3: With cfg_index_mode low, address bit 13 selects the half: 0 selects half 0 and 1 selects half 1.
- R4: With cfg_index_mode high, address bit 25 selects the half, so addresses below 0x7E000000 use half 0 and addresses from 0x7E000000 up use half 1.
- R5: For a mapped request, ram_addr is the data-store byte address. This is 4096 + addr[11:0] for half 0 and 12288 + addr[11:0] for half 1. Bit 13 of ram_addr is the half and bit 12 is always 1.
- R6: req_size is encoded as 0 byte, 1 word, 2 long and 3 burst. Storage is little-endian. A word uses addr[1] and ignores addr[0], and a long ignores addr[1:0]. A byte read or word read returns the value sign-extended to 32 bits.
- R7: A single write changes only the bytes it addresses. A byte write takes req_wdata[7:0] and a word write takes req_wdata[15:0]. All other stored bytes keep their values.
- R8: A burst (size 3) moves the 32 bytes starting at the address rounded down to a 32-byte boundary. Burst byte k sits at burst_wdata or burst_rdata bits 8k+7:8k. For a burst, ram_addr has bits 4:0 cleared.
- R9: resp_valid is high in the cycle after each request and low in the cycle after each idle cycle. Read data appears with that response.
- R10: An unmapped request leaves the store unchanged and returns rd_data, burst_rdata and ram_addr as zero. rd_data is zero unless the response is a mapped single read, and burst_rdata is zero unless it is a mapped burst read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_index_mode | input | 1 | 0: address bit 13 picks the half; 1: address bit 25 picks it |
| cfg_ram_en | input | 1 | Cache operates as RAM |
| cfg_cache_en | input | 1 | Operand cache enabled |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 write, 0 read |
| req_size | input | 2 | 0 byte, 1 word, 2 long, 3 burst |
| req_addr | input | 32 | CPU byte address |
| req_wdata | input | 32 | Single write data, right-justified |
| burst_wdata | input | 256 | Burst write data, byte k at bits 8k+7:8k |
| resp_valid | output | 1 | Response to the previous cycle's request |
| resp_unmapped | output | 1 | Previous request was not served |
| ram_addr | output | 14 | Data-store byte address used |
| rd_data | output | 32 | Sign-extended single read data |
| burst_rdata | output | 256 | Burst read data |

## Verification
Long writes are placed at addresses that differ only in bit 13 or only in bit 25. They are then read back under both index modes, so that choosing the wrong selecting bit shows up as aliased data. Byte and word stores with a set top bit are mixed with long reads of the same word. This separates sign extension on reads from byte-enable masking on writes. Bursts are written and then read back as singles, and singles are written and then read back as a burst from an unaligned address. This exposes errors in lane order and in alignment. Writes made while disabled and requests just outside the window must come back unmapped and must leave earlier data untouched.

// File: rtl/carram_pkg.sv
package carram_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE  = 2'd0,
      SZ_WORD  = 2'd1,
      SZ_LONG  = 2'd2,
      SZ_BURST = 2'd3
   } acc_size_e;

   // Replicate right-justified store data across the 32-bit lane
   function automatic logic [31:0] spread_wdata(input acc_size_e sz, input logic [31:0] wd);
      case (sz)
         SZ_BYTE: spread_wdata = {4{wd[7:0]}};
         SZ_WORD: spread_wdata = {2{wd[15:0]}};
         default: spread_wdata = wd;
      endcase
   endfunction

endpackage

// File: rtl/carram_decode.sv
module carram_decode
   import carram_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int HALF_BYTES  = 4096,
   parameter int BURST_BYTES = 32,
   parameter int BE_W        = 4,
   parameter logic [31:0] WIN_BASE = 32'h7C00_0000,
   parameter int WIN_LOG2    = 26,
   parameter int ALT_SEL_BIT = 13,
   parameter int MID_SEL_BIT = 25,
   localparam int OFF_W      = $clog2(HALF_BYTES),
   localparam int STORE_AW   = OFF_W + 2,
   localparam int BURST_LOG2 = $clog2(BURST_BYTES),
   localparam int BSEL_W     = $clog2(BE_W),
   localparam int LANES      = BURST_BYTES / BE_W,
   localparam int LANE_W     = $clog2(LANES),
   localparam int ROW_W      = OFF_W - BURST_LOG2 + 1
)(
   input  logic                 index_mode,
   input  logic                 live,
   input  logic [ADDR_W-1:0]    addr,
   input  acc_size_e            size,
   output logic                 mapped,
   output logic [STORE_AW-1:0]  store_addr,
   output logic [ROW_W-1:0]     row,
   output logic [LANE_W-1:0]    lane,
   output logic [BSEL_W-1:0]    bsel,
   output logic [BE_W-1:0]      be
);
   localparam int TAG_W = ADDR_W - WIN_LOG2;
   localparam logic [TAG_W-1:0] WIN_TAG = TAG_W'(WIN_BASE >> WIN_LOG2);

   logic              in_window;
   logic              half;
   logic [OFF_W-1:0]  off;

   assign in_window = (addr[ADDR_W-1:WIN_LOG2] == WIN_TAG);
   assign mapped    = live & in_window;
   assign off       = addr[OFF_W-1:0];

   // Half selection: bit chosen by the index mode
   assign half = index_mode ? addr[MID_SEL_BIT] : addr[ALT_SEL_BIT];

   always_comb begin
      store_addr = {half, 1'b1, off};
      if (size == SZ_BURST)
         store_addr[BURST_LOG2-1:0] = '0;
      if (!mapped)
         store_addr = '0;
   end

   assign row  = {half, off[OFF_W-1:BURST_LOG2]};
   assign lane = off[BURST_LOG2-1:BSEL_W];
   assign bsel = off[BSEL_W-1:0];

   always_comb begin
      case (size)
         SZ_BYTE: be = BE_W'(1) << bsel;
         SZ_WORD: be = bsel[BSEL_W-1] ? {2'b11, {(BE_W-2){1'b0}}} : {{(BE_W-2){1'b0}}, 2'b11};
         default: be = '1;
      endcase
   end
endmodule

// File: rtl/carram_lane.sv
module carram_lane #(
   parameter int ROWS   = 256,
   parameter int DATA_W = 32,
   localparam int BE_W  = DATA_W / 8,
   localparam int ROW_W = $clog2(ROWS)
)(
   input  logic              clk,
   input  logic              wr_en,
   input  logic [BE_W-1:0]   wr_be,
   input  logic [ROW_W-1:0]  row,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] mem [ROWS];

   always_ff @(posedge clk) begin
      for (int b = 0; b < BE_W; b++) begin
         if (wr_en && wr_be[b])
            mem[row][8*b +: 8] <= wr_data[8*b +: 8];
      end
   end

   assign rd_data = mem[row];
endmodule

// File: rtl/carram_extend.sv
module carram_extend
   import carram_pkg::*;
#(
   parameter int DATA_W = 32,
   localparam int BSEL_W = $clog2(DATA_W / 8)
)(
   input  logic [DATA_W-1:0] word,
   input  acc_size_e         size,
   input  logic [BSEL_W-1:0] bsel,
   output logic [DATA_W-1:0] value
);
   logic [DATA_W-1:0] shifted;

   always_comb begin
      shifted = word;
      value   = word;
      case (size)
         SZ_BYTE: begin
            shifted = word >> (8 * bsel);
            value   = {{(DATA_W-8){shifted[7]}}, shifted[7:0]};
         end
         SZ_WORD: begin
            shifted = word >> (8 * {bsel[BSEL_W-1], 1'b0});
            value   = {{(DATA_W-16){shifted[15]}}, shifted[15:0]};
         end
         default: value = word;
      endcase
   end
endmodule

// File: rtl/carram_mapper.sv
module carram_mapper
   import carram_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int DATA_W      = 32,
   parameter int HALF_BYTES  = 4096,
   parameter int BURST_BYTES = 32,
   parameter logic [31:0] WIN_BASE = 32'h7C00_0000,
   parameter int WIN_LOG2    = 26,
   parameter int ALT_SEL_BIT = 13,
   parameter int MID_SEL_BIT = 25,
   localparam int BE_W       = DATA_W / 8,
   localparam int BSEL_W     = $clog2(BE_W),
   localparam int OFF_W      = $clog2(HALF_BYTES),
   localparam int STORE_AW   = OFF_W + 2,
   localparam int LANES      = BURST_BYTES / BE_W,
   localparam int LANE_W     = $clog2(LANES),
   localparam int BURST_LOG2 = $clog2(BURST_BYTES),
   localparam int ROW_W      = OFF_W - BURST_LOG2 + 1,
   localparam int ROWS       = 1 << ROW_W,
   localparam int BURST_W    = BURST_BYTES * 8
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_index_mode,
   input  logic                 cfg_ram_en,
   input  logic                 cfg_cache_en,
   input  logic                 req_valid,
   input  logic                 req_write,
   input  logic [1:0]           req_size,
   input  logic [ADDR_W-1:0]    req_addr,
   input  logic [DATA_W-1:0]    req_wdata,
   input  logic [BURST_W-1:0]   burst_wdata,
   output logic                 resp_valid,
   output logic                 resp_unmapped,
   output logic [STORE_AW-1:0]  ram_addr,
   output logic [DATA_W-1:0]    rd_data,
   output logic [BURST_W-1:0]   burst_rdata
);
   initial begin
      assert (DATA_W == 32) else $error("carram_mapper: DATA_W must be 32");
      assert ((1 << OFF_W) == HALF_BYTES) else $error("carram_mapper: HALF_BYTES must be a power of two");
      assert ((1 << BURST_LOG2) == BURST_BYTES && BURST_BYTES >= BE_W && BURST_BYTES <= HALF_BYTES)
         else $error("carram_mapper: bad BURST_BYTES");
      assert (ALT_SEL_BIT > OFF_W && ALT_SEL_BIT < WIN_LOG2) else $error("carram_mapper: bad ALT_SEL_BIT");
      assert (MID_SEL_BIT > OFF_W && MID_SEL_BIT < WIN_LOG2) else $error("carram_mapper: bad MID_SEL_BIT");
   end

   acc_size_e           size;
   logic                live;
   logic                mapped;
   logic                is_burst;
   logic [STORE_AW-1:0] store_addr;
   logic [ROW_W-1:0]    row;
   logic [LANE_W-1:0]   lane;
   logic [BSEL_W-1:0]   bsel;
   logic [BE_W-1:0]     be;
   logic [DATA_W-1:0]   wd_spread;
   logic [BURST_W-1:0]  row_rd;
   logic [DATA_W-1:0]   sel_word;
   logic [DATA_W-1:0]   ext_word;

   assign size      = acc_size_e'(req_size);
   assign live      = cfg_ram_en & cfg_cache_en;
   assign is_burst  = (size == SZ_BURST);
   assign wd_spread = spread_wdata(size, req_wdata);

   carram_decode #(
      .ADDR_W(ADDR_W), .HALF_BYTES(HALF_BYTES), .BURST_BYTES(BURST_BYTES), .BE_W(BE_W),
      .WIN_BASE(WIN_BASE), .WIN_LOG2(WIN_LOG2),
      .ALT_SEL_BIT(ALT_SEL_BIT), .MID_SEL_BIT(MID_SEL_BIT)
   ) u_decode (
      .index_mode (cfg_index_mode),
      .live       (live),
      .addr       (req_addr),
      .size       (size),
      .mapped     (mapped),
      .store_addr (store_addr),
      .row        (row),
      .lane       (lane),
      .bsel       (bsel),
      .be         (be)
   );

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      logic              we;
      logic [BE_W-1:0]   lane_be;
      logic [DATA_W-1:0] lane_wd;

      assign we      = req_valid & mapped & req_write & (is_burst | (lane == LANE_W'(k)));
      assign lane_be = is_burst ? '1 : be;
      assign lane_wd = is_burst ? burst_wdata[k*DATA_W +: DATA_W] : wd_spread;

      carram_lane #(.ROWS(ROWS), .DATA_W(DATA_W)) u_lane (
         .clk     (clk),
         .wr_en   (we),
         .wr_be   (lane_be),
         .row     (row),
         .wr_data (lane_wd),
         .rd_data (row_rd[k*DATA_W +: DATA_W])
      );
   end

   assign sel_word = row_rd[lane*DATA_W +: DATA_W];

   carram_extend #(.DATA_W(DATA_W)) u_extend (
      .word  (sel_word),
      .size  (size),
      .bsel  (bsel),
      .value (ext_word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         resp_valid    <= 1'b0;
         resp_unmapped <= 1'b0;
         ram_addr      <= '0;
         rd_data       <= '0;
         burst_rdata   <= '0;
      end else begin
         resp_valid    <= req_valid;
         resp_unmapped <= req_valid & ~mapped;
         ram_addr      <= req_valid ? store_addr : '0;
         rd_data       <= (req_valid & mapped & ~req_write & ~is_burst) ? ext_word : '0;
         burst_rdata   <= (req_valid & mapped & ~req_write &  is_burst) ? row_rd : '0;
      end
   end
endmodule

// File: rtl/carram_mapper_chk.sv
module carram_mapper_chk #(
   parameter int ADDR_W      = 32,
   parameter int DATA_W      = 32,
   parameter int BURST_W     = 256,
   parameter int STORE_AW    = 14,
   parameter int OFF_W       = 12,
   parameter logic [31:0] WIN_BASE = 32'h7C00_0000,
   parameter int WIN_LOG2    = 26,
   parameter int ALT_SEL_BIT = 13,
   parameter int MID_SEL_BIT = 25
)(
   input logic                clk,
   input logic                rst_n,
   input logic                cfg_index_mode,
   input logic                cfg_ram_en,
   input logic                cfg_cache_en,
   input logic                req_valid,
   input logic                req_write,
   input logic [1:0]          req_size,
   input logic [ADDR_W-1:0]   req_addr,
   input logic                resp_valid,
   input logic                resp_unmapped,
   input logic [STORE_AW-1:0] ram_addr,
   input logic [DATA_W-1:0]   rd_data,
   input logic [BURST_W-1:0]  burst_rdata
);
   localparam int TAG_W = ADDR_W - WIN_LOG2;
   localparam logic [TAG_W-1:0] WIN_TAG = TAG_W'(WIN_BASE >> WIN_LOG2);

   AST_OUTSIDE_UNMAPPED: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_addr[ADDR_W-1:WIN_LOG2] != WIN_TAG |=> resp_unmapped); // R1
   AST_DISABLED_UNMAPPED: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !(cfg_ram_en && cfg_cache_en) |=> resp_unmapped); // R2
   AST_ALT_HALF_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !cfg_index_mode |=> resp_unmapped || ram_addr[STORE_AW-1] == $past(req_addr[ALT_SEL_BIT])); // R3
   AST_MID_HALF_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && cfg_index_mode |=> resp_unmapped || ram_addr[STORE_AW-1] == $past(req_addr[MID_SEL_BIT])); // R4
   AST_STORE_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_size != 2'd3 |=> resp_unmapped ||
      (ram_addr[OFF_W] && ram_addr[OFF_W-1:0] == $past(req_addr[OFF_W-1:0]))); // R5
   AST_BYTE_SIGN_EXT: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_write && req_size == 2'd0 |=> rd_data[DATA_W-1:8] == {(DATA_W-8){rd_data[7]}}); // R6
   AST_BURST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_size == 2'd3 |=> ram_addr[4:0] == 5'd0); // R8
   AST_RESP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> resp_valid); // R9
   AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !resp_valid && !resp_unmapped); // R9
   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      resp_unmapped |-> rd_data == '0 && burst_rdata == '0 && ram_addr == '0); // R10
   AST_WRITE_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_write |=> rd_data == '0 && burst_rdata == '0); // R10
endmodule

bind carram_mapper carram_mapper_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BURST_W(BURST_W), .STORE_AW(STORE_AW), .OFF_W(OFF_W),
   .WIN_BASE(WIN_BASE), .WIN_LOG2(WIN_LOG2), .ALT_SEL_BIT(ALT_SEL_BIT), .MID_SEL_BIT(MID_SEL_BIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_index_mode(cfg_index_mode), .cfg_ram_en(cfg_ram_en),
   .cfg_cache_en(cfg_cache_en), .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
   .req_addr(req_addr), .resp_valid(resp_valid), .resp_unmapped(resp_unmapped),
   .ram_addr(ram_addr), .rd_data(rd_data), .burst_rdata(burst_rdata)
);

// File: tb/carram_mapper_test.sv
module carram_mapper_test;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         oix = 1'b0, ora = 1'b0, oce = 1'b0;
   logic         req_valid = 1'b0, req_write = 1'b0;
   logic [1:0]   req_size = 2'd0;
   logic [31:0]  req_addr = '0, req_wdata = '0;
   logic [255:0] burst_wdata = '0;
   logic         resp_valid, resp_unmapped;
   logic [13:0]  ram_addr;
   logic [31:0]  rd_data;
   logic [255:0] burst_rdata;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   typedef struct {
      logic [31:0]  rd;
      logic [255:0] brd;
      logic [13:0]  ra;
      logic         um;
      string        tag;
   } exp_t;

   exp_t exp_q[$];
   logic [7:0] shadow [int];

   always #10 clk = ~clk;   // 50 MHz

   carram_mapper uut (
      .clk(clk), .rst_n(rst_n), .cfg_index_mode(oix), .cfg_ram_en(ora), .cfg_cache_en(oce),
      .req_valid(req_valid), .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
      .req_wdata(req_wdata), .burst_wdata(burst_wdata), .resp_valid(resp_valid),
      .resp_unmapped(resp_unmapped), .ram_addr(ram_addr), .rd_data(rd_data), .burst_rdata(burst_rdata)
   );

   task automatic check(input bit ok, input string what, input logic [255:0] act, input logic [255:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", what, act, exp);
      end
   endtask

   // Driver: drive one request and push the expected response
   task automatic access(input logic wr, input logic [1:0] sz, input logic [31:0] a,
                         input logic [31:0] wd, input logic [255:0] bwd, input string tag);
      exp_t e;
      logic mapped, half;
      logic [13:0] sa;
      int base;
      logic [31:0] w;
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a;
      req_wdata = wd; burst_wdata = bwd;
      mapped = (a[31:26] == 6'b011111) && ora && oce;
      half = oix ? a[25] : a[13];
      sa = {half, 1'b1, a[11:0]};
      if (sz == 2'd3) sa[4:0] = 5'd0;
      e.ra = mapped ? sa : 14'd0;
      e.um = !mapped;
      e.rd = '0;
      e.brd = '0;
      e.tag = tag;
      if (mapped) begin
         case (sz)
            2'd0: base = int'(sa);
            2'd1: base = int'(sa) & ~1;
            2'd2: base = int'(sa) & ~3;
            default: base = int'(sa);
         endcase
         if (wr) begin
            case (sz)
               2'd0: shadow[base] = wd[7:0];
               2'd1: for (int i = 0; i < 2; i++) shadow[base+i] = wd[8*i +: 8];
               2'd2: for (int i = 0; i < 4; i++) shadow[base+i] = wd[8*i +: 8];
               default: for (int i = 0; i < 32; i++) shadow[base+i] = bwd[8*i +: 8];
            endcase
         end else begin
            case (sz)
               2'd0: e.rd = {{24{shadow[base][7]}}, shadow[base]};
               2'd1: e.rd = {{16{shadow[base+1][7]}}, shadow[base+1], shadow[base]};
               2'd2: begin
                  for (int i = 0; i < 4; i++) w[8*i +: 8] = shadow[base+i];
                  e.rd = w;
               end
               default: for (int i = 0; i < 32; i++) e.brd[8*i +: 8] = shadow[base+i];
            endcase
         end
      end
      exp_q.push_back(e);
   endtask

   task automatic idle(input int n);
      @(negedge clk);
      req_valid = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   // Monitor: pop and compare as responses appear
   always @(negedge clk) begin
      if (rst_n && resp_valid && !done) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R9 response without request", 256'(resp_valid), 256'(0));
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            check(resp_unmapped == e.um, {e.tag, " unmapped"}, 256'(resp_unmapped), 256'(e.um));
            check(ram_addr == e.ra, {e.tag, " ram_addr (R5)"}, 256'(ram_addr), 256'(e.ra));
            check(rd_data == e.rd, {e.tag, " rd_data"}, 256'(rd_data), 256'(e.rd));
            check(burst_rdata == e.brd, {e.tag, " burst_rdata"}, burst_rdata, e.brd);
         end
      end
   end

   task automatic finish_up();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
   end

   initial begin
      logic [255:0] pat;
      repeat (3) @(negedge clk);
      check(resp_valid == 1'b0 && resp_unmapped == 1'b0 && rd_data == 32'd0,
            "R9 reset state", {resp_valid, resp_unmapped, rd_data}, 256'(0));
      rst_n = 1'b1;
      @(negedge clk);

      // R2 / R10: disabled writes are discarded
      ora = 1'b1; oce = 1'b1;
      access(1'b1, 2'd2, 32'h7C00_0040, 32'hA5A5_A5A5, '0, "R7 seed");
      idle(0);
      ora = 1'b0;
      access(1'b1, 2'd2, 32'h7C00_0040, 32'h0000_0000, '0, "R2 write ram_en low");
      access(1'b0, 2'd2, 32'h7C00_0040, '0, '0, "R2 read ram_en low");
      idle(0);
      ora = 1'b1; oce = 1'b0;
      access(1'b0, 2'd2, 32'h7C00_0040, '0, '0, "R2 read cache_en low");
      access(1'b1, 2'd0, 32'h7C00_0041, 32'h0000_0011, '0, "R10 write discarded");
      idle(0);
      oce = 1'b1;
      access(1'b0, 2'd2, 32'h7C00_0040, '0, '0, "R10 data kept after discard");

      // R3: bit 13 selects the half
      oix = 1'b0;
      access(1'b1, 2'd2, 32'h7C00_0000, 32'h1000_0000, '0, "R3 write h0");
      access(1'b1, 2'd2, 32'h7C00_1004, 32'h1000_0001, '0, "R3 write h0 page1");
      access(1'b1, 2'd2, 32'h7C00_2000, 32'h2000_0000, '0, "R3 write h1");
      access(1'b1, 2'd2, 32'h7E00_3008, 32'h2000_0002, '0, "R3 write h1 high");
      access(1'b0, 2'd2, 32'h7C00_0000, '0, '0, "R3 read h0");
      access(1'b0, 2'd2, 32'h7C00_1004, '0, '0, "R3 read h0 page1");
      access(1'b0, 2'd2, 32'h7C00_2000, '0, '0, "R3 read h1");
      access(1'b0, 2'd2, 32'h7C00_E000, '0, '0, "R3 alias in next 16K");
      access(1'b0, 2'd2, 32'h7E00_3008, '0, '0, "R3 read h1 high");
      idle(0);

      // R4: bit 25 selects the half
      oix = 1'b1;
      access(1'b0, 2'd2, 32'h7E00_0000, '0, '0, "R4 read upper half");
      access(1'b0, 2'd2, 32'h7DFF_F004, '0, '0, "R4 read just below mid");
      access(1'b0, 2'd2, 32'h7C00_2000, '0, '0, "R4 bit13 ignored");
      access(1'b0, 2'd2, 32'h7E00_1008, '0, '0, "R4 upper offset");
      idle(0);

      // R6 / R7: sizes, sign extension, byte enables
      oix = 1'b0;
      access(1'b1, 2'd0, 32'h7C00_0100, 32'hFFFF_FF80, '0, "R7 byte0");
      access(1'b1, 2'd0, 32'h7C00_0101, 32'h0000_007F, '0, "R7 byte1");
      access(1'b1, 2'd1, 32'h7C00_0103, 32'h1234_8001, '0, "R7 word hi");
      access(1'b0, 2'd0, 32'h7C00_0100, '0, '0, "R6 byte neg");
      access(1'b0, 2'd0, 32'h7C00_0101, '0, '0, "R6 byte pos");
      access(1'b0, 2'd1, 32'h7C00_0102, '0, '0, "R6 word neg");
      access(1'b0, 2'd1, 32'h7C00_0101, '0, '0, "R6 word low ignores bit0");
      access(1'b0, 2'd2, 32'h7C00_0103, '0, '0, "R6 long ignores low bits");
      access(1'b1, 2'd0, 32'h7C00_0103, 32'h0000_0012, '0, "R7 byte3");
      access(1'b0, 2'd2, 32'h7C00_0100, '0, '0, "R7 long after byte");

      // R8: bursts
      for (int i = 1; i < 8; i++)
         access(1'b1, 2'd2, 32'h7C00_0100 + 32'(4*i), 32'hC0DE_0000 + 32'(i), '0, "R8 fill");
      access(1'b0, 2'd3, 32'h7C00_0113, '0, '0, "R8 burst read unaligned");
      for (int i = 0; i < 32; i++) pat[8*i +: 8] = 8'(8'h90 + i);
      access(1'b1, 2'd3, 32'h7C00_2040, '0, pat, "R8 burst write");
      access(1'b0, 2'd2, 32'h7C00_2040, '0, '0, "R8 first long");
      access(1'b0, 2'd2, 32'h7C00_205C, '0, '0, "R8 last long");
      access(1'b0, 2'd0, 32'h7C00_205F, '0, '0, "R8 last byte");
      access(1'b0, 2'd3, 32'h7C00_205C, '0, '0, "R8 burst readback");

      // R1: outside the window
      access(1'b0, 2'd2, 32'h8000_0000, '0, '0, "R1 above window");
      access(1'b1, 2'd2, 32'h7BFF_FFFC, 32'hFFFF_FFFF, '0, "R1 below window");
      access(1'b0, 2'd2, 32'h3C00_0000, '0, '0, "R1 alias low");
      access(1'b0, 2'd3, 32'h7BFF_FFE0, '0, '0, "R1 burst below");
      idle(4);

      check(exp_q.size() == 0, "R9 all responses seen", 256'(exp_q.size()), 256'(0));
      check(resp_valid == 1'b0, "R9 idle after traffic", 256'(resp_valid), 256'(0));
      finish_up();
   end
endmodule